// File: doc/BRIEF.md
# Tag-Only Cache Event Monitor

This block shadows a memory path with a set-associative tag directory. It holds no data. Each observed access gives a byte address, a byte count and a read/write flag. The block replays that access against its tag array and updates seven event counters:

- read hits and read misses
- write hits and write misses
- evictions of dirty lines
- reads that bypassed the cache
- writes that bypassed the cache

An access that bypasses the cache is a miss in a set where every way is pinned, so no line can be replaced. Replacement is least-recently-used. The age of a line is a stamp taken from a free-running cycle count at its last touch.

Requests arrive on a valid/ready channel. The block accepts a request only when `req_ready` is high, and it holds `req_ready` low from acceptance until the request's result is reported. While `req_ready` is low, a producer must hold the request. An access that spans several lines is walked one line per clock. The result is a one-cycle `done_valid` pulse that carries the number of misses for the request. That pulse has no back-pressure.

A side channel marks a resident line as pinned or dirty. A clear input zeroes only the counters. Cache size, line size, way count and the write-allocate choice are parameters. A way count of zero makes the cache fully associative. An illegal geometry stops elaboration:

- a size that is not a power of two
- a line shorter than 4 bytes
- a cache smaller than one line
- more ways than lines

Top module: `tag_cache_monitor`

## Requirements
- R1: An access to a line is a hit only when a valid way of its set stores exactly its line number, where line number = address >> log2(LINE_BYTES). A hit adds one to the read-hit or write-hit counter and changes no tag.
- R2: The set of a line is its line number modulo the number of sets. Lines whose numbers differ only above the set bits compete for the ways of one set.
- R3: A request covers bytes address to address+size-1, and a size of 0 covers one byte. It performs one lookup for every line from the first to the last. Each lookup updates the counters on its own.
- R4: `req_ready` is high only when idle, and it falls for the cycle after acceptance. A request of L lines raises `done_valid` for one cycle, L clock edges after the accepting edge.
- R5: On a miss the victim is the first invalid way in way order. If every way is valid, the victim is the unpinned way with the oldest access, and a tie goes to the lower way. A hit refreshes the age of its line.
- R6: A miss in a set whose ways are all valid and pinned leaves the set unchanged. It still counts as a read or write miss, and it adds one to the read-around or write-around counter.
- R7: Replacing a valid dirty line adds one to the dirty-writeback counter. The refilled line is valid, unpinned and clean.
- R8: A read miss adds 1 to `done_misses`. A write miss adds 1 only when WRITE_ALLOC is 1. Both kinds of miss refill a line.
- R9: A mark (`mark_en` with `mark_line`) sets the pin and dirty flags of the resident line to `mark_pin` and `mark_dirty`, but only in a cycle where `req_ready` is high. A mark made while a request is walking, or a mark for a line that is not resident, has no effect.
- R10: `clr_counts` zeroes all seven counters on the next edge and leaves the tag state intact.
- R11: After reset all counters are zero, no line is valid, `req_ready` is 1 and `done_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | SZ_W | Byte count (0 is treated as 1) |
| req_read | input | 1 | 1 for read, 0 for write |
| done_valid | output | 1 | One-cycle pulse when a request completes |
| done_misses | output | MISS_W | Misses counted for the completed request |
| mark_en | input | 1 | Apply pin/dirty flags to a resident line |
| mark_line | input | ADDR_W-log2(LINE_BYTES) | Line number to mark |
| mark_pin | input | 1 | New pin flag |
| mark_dirty | input | 1 | New dirty flag |
| clr_counts | input | 1 | Zero all event counters |
| cnt_rd_hit | output | CNT_W | Read-hit count |
| cnt_rd_miss | output | CNT_W | Read-miss count |
| cnt_wr_hit | output | CNT_W | Write-hit count |
| cnt_wr_miss | output | CNT_W | Write-miss count |
| cnt_wback | output | CNT_W | Dirty-line eviction count |
| cnt_rd_around | output | CNT_W | Reads that bypassed a fully pinned set |
| cnt_wr_around | output | CNT_W | Writes that bypassed a fully pinned set |

## Verification
A corrupted tag, valid bit or age does not show on its own. It shows at the first later lookup to the affected set, as a hit where a miss was due or the reverse. That lookup changes `done_misses` and a counter within the same request. A wrong victim choice shows one access later, when the line that should have survived misses. For this reason the bench keeps a line-level model and compares every counter after every request, so that a fault is caught at the first access that can expose it.

// File: rtl/cm_pkg.sv
`timescale 1ns/1ps
package cm_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } cm_state_e;

  // event bit positions in the counter bump vector
  localparam int EV_N         = 7;
  localparam int EV_RD_HIT    = 0;
  localparam int EV_RD_MISS   = 1;
  localparam int EV_WR_HIT    = 2;
  localparam int EV_WR_MISS   = 3;
  localparam int EV_WBACK     = 4;
  localparam int EV_RD_AROUND = 5;
  localparam int EV_WR_AROUND = 6;

  function automatic bit is_pow2(input longint v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/cm_stamp.sv
`timescale 1ns/1ps
module cm_stamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

endmodule

// File: rtl/cm_event_counters.sv
`timescale 1ns/1ps
module cm_event_counters #(
  parameter int CNT_W = 64,
  parameter int N     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N-1:0]     bump,
  output logic [CNT_W-1:0] cnt [N]
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (clr)          cnt[i] <= '0;
        else if (bump[i]) cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt[g] == '0));
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((cnt[g] == $past(cnt[g])) || (cnt[g] == $past(cnt[g]) + 1'b1)));
  end

endmodule

// File: rtl/cm_set_probe.sv
`timescale 1ns/1ps
module cm_set_probe #(
  parameter int NWAY  = 2,
  parameter int BLK_W = 12,
  parameter int TS_W  = 32,
  parameter int WAY_W = 1
) (
  input  logic [BLK_W-1:0] key,
  input  logic [NWAY-1:0]  vld,
  input  logic [NWAY-1:0]  pin,
  input  logic [BLK_W-1:0] tags   [NWAY],
  input  logic [TS_W-1:0]  stamps [NWAY],
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic             vic_found,
  output logic [WAY_W-1:0] vic_way
);

  logic [TS_W-1:0] best;
  logic            stop;

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < NWAY; w++) begin
      if (!hit && vld[w] && (tags[w] == key)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  // first invalid way wins outright; otherwise oldest unpinned, low way on tie
  always_comb begin
    vic_found = 1'b0;
    vic_way   = '0;
    best      = '1;
    stop      = 1'b0;
    for (int w = 0; w < NWAY; w++) begin
      if (!stop) begin
        if (!vld[w]) begin
          vic_found = 1'b1;
          vic_way   = WAY_W'(w);
          stop      = 1'b1;
        end else if (!pin[w] && (!vic_found || (stamps[w] < best))) begin
          vic_found = 1'b1;
          vic_way   = WAY_W'(w);
          best      = stamps[w];
        end
      end
    end
  end

endmodule

// File: rtl/tag_cache_monitor.sv
`timescale 1ns/1ps
module tag_cache_monitor
  import cm_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SZ_W        = 6,
  parameter int CACHE_BYTES = 256,
  parameter int LINE_BYTES  = 16,
  parameter int WAYS        = 2,
  parameter bit WRITE_ALLOC = 1'b1,
  parameter int TS_W        = 32,
  parameter int CNT_W       = 64,
  localparam int MAXL   = ((1 << SZ_W) - 1 + LINE_BYTES - 1) / LINE_BYTES + 1,
  localparam int MISS_W = $clog2(MAXL + 1),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int BLK_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_read,
  output logic              done_valid,
  output logic [MISS_W-1:0] done_misses,
  input  logic              mark_en,
  input  logic [BLK_W-1:0]  mark_line,
  input  logic              mark_pin,
  input  logic              mark_dirty,
  input  logic              clr_counts,
  output logic [CNT_W-1:0]  cnt_rd_hit,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_hit,
  output logic [CNT_W-1:0]  cnt_wr_miss,
  output logic [CNT_W-1:0]  cnt_wback,
  output logic [CNT_W-1:0]  cnt_rd_around,
  output logic [CNT_W-1:0]  cnt_wr_around
);

  localparam int LINES  = CACHE_BYTES / LINE_BYTES;
  localparam int NWAY   = (WAYS == 0) ? LINES : WAYS;
  localparam int NSET   = LINES / NWAY;
  localparam int SET_W  = (NSET > 1) ? $clog2(NSET) : 1;
  localparam int WAY_W  = (NWAY > 1) ? $clog2(NWAY) : 1;
  localparam int SLOT_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam bit CFG_OK = is_pow2(CACHE_BYTES) && is_pow2(LINE_BYTES) &&
                          ((WAYS == 0) || is_pow2(WAYS)) && (LINE_BYTES >= 4) &&
                          (CACHE_BYTES >= LINE_BYTES) && (WAYS <= LINES);

  if (!CFG_OK) begin : g_bad_cfg
    $error("tag_cache_monitor: illegal cache geometry");
  end

  // ---------------- tag directory state ----------------
  logic [LINES-1:0] vld_q, pin_q, dty_q;
  logic [BLK_W-1:0] tag_q [LINES];
  logic [TS_W-1:0]  ts_q  [LINES];

  // ---------------- request walker state ----------------
  cm_state_e         state_q;
  logic [BLK_W-1:0]  cur_blk_q, last_blk_q;
  logic              rd_q;
  logic [MISS_W-1:0] miss_q;
  logic              done_q;
  logic [MISS_W-1:0] done_miss_q;

  logic [TS_W-1:0] now;

  cm_stamp #(.TS_W(TS_W)) u_stamp (
    .clk  (clk),
    .rst_n(rst_n),
    .now  (now)
  );

  logic walking;
  logic accept;
  assign walking   = (state_q == ST_WALK);
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // the probe serves the walker, or the mark port while idle
  logic [BLK_W-1:0] lk_blk;
  logic [SET_W-1:0] lk_set;
  assign lk_blk = walking ? cur_blk_q : mark_line;
  assign lk_set = SET_W'(lk_blk & BLK_W'(NSET - 1));

  function automatic logic [SLOT_W-1:0] slot_of(input logic [SET_W-1:0] s,
                                                input logic [WAY_W-1:0] w);
    return SLOT_W'(int'(s) * NWAY + int'(w));
  endfunction

  logic [NWAY-1:0]  lk_vld, lk_pin, lk_dty;
  logic [BLK_W-1:0] lk_tags [NWAY];
  logic [TS_W-1:0]  lk_ts   [NWAY];

  always_comb begin
    for (int w = 0; w < NWAY; w++) begin
      lk_vld[w]  = vld_q[slot_of(lk_set, WAY_W'(w))];
      lk_pin[w]  = pin_q[slot_of(lk_set, WAY_W'(w))];
      lk_dty[w]  = dty_q[slot_of(lk_set, WAY_W'(w))];
      lk_tags[w] = tag_q[slot_of(lk_set, WAY_W'(w))];
      lk_ts[w]   = ts_q[slot_of(lk_set, WAY_W'(w))];
    end
  end

  logic             lk_hit, lk_vic_found;
  logic [WAY_W-1:0] lk_hit_way, lk_vic_way;

  cm_set_probe #(
    .NWAY (NWAY),
    .BLK_W(BLK_W),
    .TS_W (TS_W),
    .WAY_W(WAY_W)
  ) u_probe (
    .key      (lk_blk),
    .vld      (lk_vld),
    .pin      (lk_pin),
    .tags     (lk_tags),
    .stamps   (lk_ts),
    .hit      (lk_hit),
    .hit_way  (lk_hit_way),
    .vic_found(lk_vic_found),
    .vic_way  (lk_vic_way)
  );

  logic [SLOT_W-1:0] hit_slot, vic_slot;
  assign hit_slot = slot_of(lk_set, lk_hit_way);
  assign vic_slot = slot_of(lk_set, lk_vic_way);

  // ---------------- per-lookup events ----------------
  logic          lk_miss, miss_inc;
  logic [EV_N-1:0] bump;

  assign lk_miss  = walking && !lk_hit;
  assign miss_inc = lk_miss && (rd_q || WRITE_ALLOC);

  always_comb begin
    bump               = '0;
    bump[EV_RD_HIT]    = walking &&  lk_hit &&  rd_q;
    bump[EV_WR_HIT]    = walking &&  lk_hit && !rd_q;
    bump[EV_RD_MISS]   = lk_miss &&  rd_q;
    bump[EV_WR_MISS]   = lk_miss && !rd_q;
    bump[EV_RD_AROUND] = lk_miss && !lk_vic_found &&  rd_q;
    bump[EV_WR_AROUND] = lk_miss && !lk_vic_found && !rd_q;
    bump[EV_WBACK]     = lk_miss && lk_vic_found &&
                         lk_vld[lk_vic_way] && lk_dty[lk_vic_way];
  end

  logic [CNT_W-1:0] cnt [EV_N];

  cm_event_counters #(.CNT_W(CNT_W), .N(EV_N)) u_counters (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_counts),
    .bump (bump),
    .cnt  (cnt)
  );

  assign cnt_rd_hit    = cnt[EV_RD_HIT];
  assign cnt_rd_miss   = cnt[EV_RD_MISS];
  assign cnt_wr_hit    = cnt[EV_WR_HIT];
  assign cnt_wr_miss   = cnt[EV_WR_MISS];
  assign cnt_wback     = cnt[EV_WBACK];
  assign cnt_rd_around = cnt[EV_RD_AROUND];
  assign cnt_wr_around = cnt[EV_WR_AROUND];

  // ---------------- tag directory update ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      pin_q <= '0;
      dty_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        ts_q[i]  <= '1;
      end
    end else if (walking) begin
      if (lk_hit) begin
        ts_q[hit_slot] <= now;
      end else if (lk_vic_found) begin
        vld_q[vic_slot] <= 1'b1;
        pin_q[vic_slot] <= 1'b0;
        dty_q[vic_slot] <= 1'b0;
        tag_q[vic_slot] <= cur_blk_q;
        ts_q[vic_slot]  <= now;
      end
    end else if (mark_en && lk_hit) begin
      pin_q[hit_slot] <= mark_pin;
      dty_q[hit_slot] <= mark_dirty;
    end
  end

  // ---------------- request walker ----------------
  logic [BLK_W-1:0] first_blk, end_blk;
  assign first_blk = BLK_W'(req_addr >> OFF_W);
  assign end_blk   = BLK_W'((req_addr + ((req_size == '0) ? ADDR_W'(0)
                                           : ADDR_W'(req_size) - ADDR_W'(1))) >> OFF_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_blk_q   <= '0;
      last_blk_q  <= '0;
      rd_q        <= 1'b0;
      miss_q      <= '0;
      done_q      <= 1'b0;
      done_miss_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q    <= ST_WALK;
        cur_blk_q  <= first_blk;
        last_blk_q <= end_blk;
        rd_q       <= req_read;
        miss_q     <= '0;
      end else if (walking) begin
        miss_q <= miss_q + MISS_W'(miss_inc);
        if (cur_blk_q == last_blk_q) begin
          state_q     <= ST_IDLE;
          done_q      <= 1'b1;
          done_miss_q <= miss_q + MISS_W'(miss_inc);
        end else begin
          cur_blk_q <= cur_blk_q + 1'b1;
        end
      end
    end
  end

  assign done_valid  = done_q;
  assign done_misses = done_miss_q;

  // ---------------- assertions ----------------
  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R4
  done_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ($past(state_q) == ST_WALK) && req_ready);
  // R7
  refill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && !lk_hit && lk_vic_found) |=>
      (vld_q[$past(vic_slot)] && !pin_q[$past(vic_slot)] && !dty_q[$past(vic_slot)] &&
       (tag_q[$past(vic_slot)] == $past(cur_blk_q))));
  // R6
  around_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && !lk_hit && !lk_vic_found) |=>
      ($stable(vld_q) && $stable(pin_q) && $stable(dty_q)));
  // R5
  stamp_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && lk_hit) |=> (ts_q[$past(hit_slot)] == $past(now)));
  // R9
  busy_mark_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && lk_hit) |=> ($stable(pin_q) && $stable(dty_q)));

endmodule

// File: tb/tag_cache_monitor_test.sv
`timescale 1ns/1ps
module tag_cache_monitor_test;

  localparam int ADDR_W = 16;
  localparam int SZ_W   = 6;
  localparam int CB     = 256;
  localparam int LB     = 16;
  localparam int WY     = 2;
  localparam int NL     = CB / LB;
  localparam int NS     = NL / WY;
  localparam bit WA     = 1'b0;

  logic clk, rst_n;
  logic req_valid, req_ready, req_read;
  logic [ADDR_W-1:0] req_addr;
  logic [SZ_W-1:0]   req_size;
  logic done_valid;
  logic [2:0] done_misses;
  logic mark_en, mark_pin, mark_dirty, clr_counts;
  logic [ADDR_W-5:0] mark_line;
  logic [63:0] c_rh, c_rm, c_wh, c_wm, c_wb, c_ra, c_wa;

  tag_cache_monitor #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W), .CACHE_BYTES(CB), .LINE_BYTES(LB),
    .WAYS(WY), .WRITE_ALLOC(WA), .TS_W(32), .CNT_W(64)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_read(req_read),
    .done_valid(done_valid), .done_misses(done_misses),
    .mark_en(mark_en), .mark_line(mark_line), .mark_pin(mark_pin),
    .mark_dirty(mark_dirty), .clr_counts(clr_counts),
    .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm), .cnt_wr_hit(c_wh), .cnt_wr_miss(c_wm),
    .cnt_wback(c_wb), .cnt_rd_around(c_ra), .cnt_wr_around(c_wa)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // line-level reference model
  bit     mv [NL];
  int     mtag [NL];
  bit     mp [NL];
  bit     md [NL];
  longint mts [NL];
  longint mstamp = 0;
  longint e_cnt [7];
  string  cnt_name [7] = '{"rd_hit", "rd_miss", "wr_hit", "wr_miss", "wback",
                           "rd_around", "wr_around"};

  task automatic check(input string r, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  function automatic longint get_cnt(input int k);
    case (k)
      0: return longint'(c_rh);
      1: return longint'(c_rm);
      2: return longint'(c_wh);
      3: return longint'(c_wm);
      4: return longint'(c_wb);
      5: return longint'(c_ra);
      default: return longint'(c_wa);
    endcase
  endfunction

  task automatic check_counts(input string r);
    for (int k = 0; k < 7; k++) check(r, cnt_name[k], get_cnt(k), e_cnt[k]);
  endtask

  function automatic int model_line(input int blk, input bit rd);
    int base, v, hs;
    longint best;
    base = (blk % NS) * WY;
    hs = -1;
    for (int w = 0; w < WY; w++)
      if (hs < 0 && mv[base+w] && mtag[base+w] == blk) hs = base + w;
    mstamp++;
    if (hs >= 0) begin
      mts[hs] = mstamp;
      e_cnt[rd ? 0 : 2]++;
      return 0;
    end
    e_cnt[rd ? 1 : 3]++;
    v = -1;
    best = 0;
    for (int w = 0; w < WY; w++) begin
      if (!mv[base+w]) begin v = base + w; break; end
      if (!mp[base+w] && (v < 0 || mts[base+w] < best)) begin
        v = base + w; best = mts[base+w];
      end
    end
    if (v < 0) e_cnt[rd ? 5 : 6]++;
    else begin
      if (mv[v] && md[v]) e_cnt[4]++;
      mv[v] = 1; mtag[v] = blk; mp[v] = 0; md[v] = 0; mts[v] = mstamp;
    end
    return (rd || WA) ? 1 : 0;
  endfunction

  task automatic do_req(input int addr, input int size, input bit rd, input string r,
                        input bit bm = 0, input int bm_line = 0);
    int first, last, nl, exp_miss, n;
    first = addr >> 4;
    last  = (addr + ((size == 0) ? 0 : size - 1)) >> 4;
    nl = last - first + 1;
    exp_miss = 0;
    for (int b = first; b <= last; b++) exp_miss += model_line(b, rd);
    @(negedge clk);
    check(r, "ready before request", longint'(req_ready), 1);
    req_valid = 1; req_addr = ADDR_W'(addr); req_size = SZ_W'(size); req_read = rd;
    @(posedge clk);
    #1 req_valid = 0;
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (bm && n == 1) begin
        mark_en = 1; mark_line = 12'(bm_line); mark_pin = 1; mark_dirty = 1;
      end
      if (n == 1) check("R4", "ready while walking", longint'(req_ready), 0);
      if (n == 2) mark_en = 0;
      if (done_valid || n > 64) break;
    end
    mark_en = 0;
    check(r, "done latency", n, nl + 1);
    check(r, "done_misses", longint'(done_misses), exp_miss);
    check_counts(r);
    @(negedge clk);
    check("R4", "done is one cycle", longint'(done_valid), 0);
  endtask

  task automatic do_mark(input int addr, input bit pin, input bit dirty);
    int blk, base;
    blk = addr >> 4;
    base = (blk % NS) * WY;
    for (int w = 0; w < WY; w++)
      if (mv[base+w] && mtag[base+w] == blk) begin mp[base+w] = pin; md[base+w] = dirty; end
    @(negedge clk);
    mark_en = 1; mark_line = 12'(blk); mark_pin = pin; mark_dirty = dirty;
    @(posedge clk);
    #1 mark_en = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned lf;
    rst_n = 0; req_valid = 0; req_addr = '0; req_size = '0; req_read = 0;
    mark_en = 0; mark_line = '0; mark_pin = 0; mark_dirty = 0; clr_counts = 0;
    for (int i = 0; i < NL; i++) begin mv[i] = 0; mp[i] = 0; md[i] = 0; mts[i] = 0; mtag[i] = 0; end
    for (int k = 0; k < 7; k++) e_cnt[k] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R11", "ready in reset", longint'(req_ready), 1);
    check("R11", "done in reset", longint'(done_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check_counts("R11");

    // R1 R3: cold sweep, 4-byte reads, one miss then three hits per 16-byte line
    for (int a = 0; a < 256; a += 4) do_req(a, 4, 1, "R1");
    check("R1", "sweep read misses", longint'(c_rm), 16);
    check("R1", "sweep read hits", longint'(c_rh), 48);
    // R1: warm sweep, all hits
    for (int a = 0; a < 256; a += 4) do_req(a, 4, 1, "R1");
    check("R1", "warm read hits", longint'(c_rh), 112);

    // R2 R5: conflicting lines evict the least recently used way
    for (int a = 256; a < 512; a += 16) do_req(a, 1, 1, "R2");
    check("R2", "conflict misses", longint'(c_rm), 32);
    for (int a = 0; a < 256; a += 16) do_req(a, 1, 1, "R5");
    check("R5", "lru re-misses", longint'(c_rm), 48);

    // R3 R4: line-crossing and zero-size requests
    do_req(14, 4, 1, "R3");
    do_req(20, 0, 1, "R3");
    do_req(1, 63, 1, "R3");
    do_req(15, 63, 1, "R3");
    do_req(0, 48, 0, "R3");

    // R8: write miss refills but counts no miss without write-allocate
    do_req(640, 4, 0, "R8");
    do_req(640, 4, 1, "R8");
    check("R8", "read after write miss hits", longint'(done_misses), 0);

    // R6: fully pinned set makes misses go around
    do_req(48, 1, 1, "R6");
    do_req(176, 1, 1, "R6");
    do_mark(48, 1, 0);
    do_mark(176, 1, 0);
    do_req(304, 1, 1, "R6");
    check("R6", "read around", longint'(c_ra), 1);
    do_req(48, 1, 1, "R6");
    do_req(176, 1, 1, "R6");
    do_req(432, 2, 0, "R6");
    check("R6", "write around", longint'(c_wa), 1);
    do_mark(48, 0, 0);
    do_req(304, 1, 1, "R6");
    do_req(48, 1, 1, "R6");

    // R7: dirty victim counts a writeback
    do_mark(176, 0, 1);
    do_req(304, 1, 1, "R7");
    check("R7", "writeback count", longint'(c_wb), 1);
    do_req(176, 1, 1, "R7");

    // R9: marks of absent lines or while busy have no effect
    do_mark(4000, 1, 1);
    do_req(80, 1, 1, "R9");
    do_req(208, 1, 1, "R9");
    do_req(0, 63, 1, "R9", 1, 5);
    do_req(336, 1, 1, "R9");
    do_req(80, 1, 1, "R9");
    check("R9", "busy mark ignored", longint'(c_ra), 1);

    // R10: clear zeroes counters, keeps tags
    @(negedge clk);
    clr_counts = 1;
    @(posedge clk);
    #1 clr_counts = 0;
    for (int k = 0; k < 7; k++) e_cnt[k] = 0;
    @(negedge clk);
    check_counts("R10");
    do_req(80, 1, 1, "R10");
    check("R10", "hit after clear", longint'(c_rh), 1);

    // R1 R5 R9: pseudo-random sweep
    lf = 32'h1234_5678;
    for (int i = 0; i < 500; i++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      if (lf[27:25] == 3'd0) do_mark(int'(lf[15:6]), lf[5], lf[4]);
      else do_req(int'(lf[15:6]), int'(lf[21:16]), lf[3], "R5");
    end

    finish_run();
  end

endmodule